// File: doc/BRIEF.md
# 100BASE-X Transmit Code-Group Framer

This block sits between a MAC's nibble-wide transmit interface and a 100BASE-X line coder. On every clock it takes one 4-bit nibble, with its enable and error qualifiers, and produces one 5-bit code-group. Between frames it sends a steady stream of IDLE code-groups. When a frame begins, the first preamble octet is replaced by the J/K start delimiter. The remaining nibbles go through the 4B/5B table. When the enable drops, the block adds the T/R end delimiter and then returns to IDLE.

Next to the parallel code-group, the block gives five line levels per clock. In fiber mode these levels are the code-group after NRZI conversion, with the first bit in line order placed at the most significant position. The line level carries over from one code-group to the next. Outside fiber mode the same output carries the code-group unchanged, so a later stage can serialize either form. The block does not scramble, does not apply MLT-3 coding and does no receive-side work.

Top module: `fx_tx_framer`

## Requirements
- R1: After reset, `codeGroup` is IDLE (11111), the delimiter machine is idle, and the NRZI line level is 0, so `lineBits` reads 00000 in fiber mode.
- R2: While `txEn` is low and no delimiter is pending, every clock edge loads IDLE (11111) into `codeGroup`.
- R3: At the edge where `txEn` is first seen high, `codeGroup` becomes J (11000). At the next edge it becomes K (10001) whatever `txEn` is. The nibbles sampled at these two edges are dropped.
- R4: After K, every edge that samples `txEn` high with `txErr` low loads the 4B/5B code of `txData`. Nibbles 0 to F map to 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101.
- R5: The first edge after K that samples `txEn` low loads T (01101). The next edge loads R (00111). After that, IDLE is loaded unless R10 applies.
- R6: A data edge, as in R4, that samples `txErr` high loads H (00100) in place of the data code-group.
- R7: `txErr` has no effect on edges that load IDLE, J, K, T or R.
- R8: With `fiberMode` high, `lineBits` is the NRZI form of `codeGroup`. Bit 4 is sent first and bit 0 last. Each 1 bit toggles the line level and each 0 bit holds it. The starting level is the last level of the previous code-group.
- R9: With `fiberMode` low, `lineBits` equals `codeGroup`. The NRZI level is still tracked, so fiber mode can resume without a break.
- R10: If `txEn` rises while T or R is pending, both T and R are still sent. J is loaded at the first edge after R is loaded that samples `txEn` high.
- R11: A frame whose enable lasts one or two cycles still produces the full sequence J, K, T, R.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit clock, one nibble per rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| txData | input | 4 | Transmit nibble from the MAC |
| txEn | input | 1 | Transmit enable, frames the packet |
| txErr | input | 1 | Transmit error, forces H on data edges |
| fiberMode | input | 1 | Selects NRZI (1) or plain code-group (0) on `lineBits` |
| codeGroup | output | 5 | Registered 5-bit code-group |
| lineBits | output | 5 | Five line levels for this clock, bit 4 sent first |

## Verification
The embedded properties assume that `txEn`, `txErr` and `txData` change only away from the rising edge. They also assume that `fiberMode` is a quasi-static select, and that reset is released before any frame starts. The bench meets these assumptions by driving every input two time units after a rising edge, so each value is stable well before the next sampling edge. The bench also changes `fiberMode` only between frames, while idle symbols are being sent.

The stimulus sweeps every nibble, with and without `txErr`, in both output modes. It also covers frames that are one and two cycles long, and an enable that rises again while T or R is pending. This keeps all delimiter transitions inside the ordering described above.

// File: rtl/fxTxPkg.sv
package fxTxPkg;

  localparam int SYM_W = 5;
  localparam int NIB_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEND_J,
    ST_SEND_K,
    ST_DATA,
    ST_SEND_T,
    ST_SEND_R
  } txState_e;

  // Strobes from control to datapath: which symbol to load at this edge.
  // All zero means load IDLE.
  typedef struct packed {
    logic selJ;
    logic selK;
    logic selData;
    logic selT;
    logic selR;
  } symStrb_t;

  localparam logic [SYM_W-1:0] CG_IDLE = 5'b11111;
  localparam logic [SYM_W-1:0] CG_J    = 5'b11000;
  localparam logic [SYM_W-1:0] CG_K    = 5'b10001;
  localparam logic [SYM_W-1:0] CG_T    = 5'b01101;
  localparam logic [SYM_W-1:0] CG_R    = 5'b00111;
  localparam logic [SYM_W-1:0] CG_H    = 5'b00100;

  function automatic logic [SYM_W-1:0] encNibble(input logic [NIB_W-1:0] nib);
    logic [SYM_W-1:0] cg;
    case (nib)
      4'h0: cg = 5'b11110;
      4'h1: cg = 5'b01001;
      4'h2: cg = 5'b10100;
      4'h3: cg = 5'b10101;
      4'h4: cg = 5'b01010;
      4'h5: cg = 5'b01011;
      4'h6: cg = 5'b01110;
      4'h7: cg = 5'b01111;
      4'h8: cg = 5'b10010;
      4'h9: cg = 5'b10011;
      4'hA: cg = 5'b10110;
      4'hB: cg = 5'b10111;
      4'hC: cg = 5'b11010;
      4'hD: cg = 5'b11011;
      4'hE: cg = 5'b11100;
      default: cg = 5'b11101;
    endcase
    return cg;
  endfunction

endpackage

// File: rtl/fx_tx_ctrl.sv
module fx_tx_ctrl
  import fxTxPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     txEn,
  output symStrb_t strb
);

  txState_e state;
  txState_e stateNext;

  always_comb begin
    strb      = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (txEn) begin
          strb.selJ = 1'b1;
          stateNext = ST_SEND_J;
        end
      end
      ST_SEND_J: begin
        strb.selK = 1'b1;
        stateNext = ST_SEND_K;
      end
      ST_SEND_K, ST_DATA: begin
        if (txEn) begin
          strb.selData = 1'b1;
          stateNext    = ST_DATA;
        end else begin
          strb.selT = 1'b1;
          stateNext = ST_SEND_T;
        end
      end
      ST_SEND_T: begin
        strb.selR = 1'b1;
        stateNext = ST_SEND_R;
      end
      ST_SEND_R: begin
        if (txEn) begin
          strb.selJ = 1'b1;
          stateNext = ST_SEND_J;
        end else begin
          stateNext = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  // R3
  j_then_k_chk: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_SEND_J |=> state == ST_SEND_K);

  // R5
  t_then_r_chk: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_SEND_T |=> state == ST_SEND_R);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !txEn) |=> state == ST_IDLE);

  // R10
  restart_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SEND_T && txEn) |=> state == ST_SEND_R);

  // R4
  data_stay_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DATA && txEn) |=> state == ST_DATA);

endmodule

// File: rtl/fx_tx_dpath.sv
module fx_tx_dpath
  import fxTxPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  symStrb_t         strb,
  input  logic [NIB_W-1:0] txData,
  input  logic             txErr,
  input  logic             fiberMode,
  output logic [SYM_W-1:0] codeGroup,
  output logic [SYM_W-1:0] lineBits
);

  logic [SYM_W-1:0] codeReg;
  logic [SYM_W-1:0] codeNext;
  logic [SYM_W-1:0] nrziReg;
  logic [SYM_W-1:0] nrziNext;

  always_comb begin
    if (strb.selJ)         codeNext = CG_J;
    else if (strb.selK)    codeNext = CG_K;
    else if (strb.selData) codeNext = txErr ? CG_H : encNibble(txData);
    else if (strb.selT)    codeNext = CG_T;
    else if (strb.selR)    codeNext = CG_R;
    else                   codeNext = CG_IDLE;
  end

  // NRZI: walk from MSB (first on line) to LSB, starting at last level sent.
  always_comb begin
    logic lvl;
    lvl = nrziReg[0];
    for (int i = SYM_W - 1; i >= 0; i--) begin
      lvl         = lvl ^ codeNext[i];
      nrziNext[i] = lvl;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      codeReg <= CG_IDLE;
      nrziReg <= '0;
    end else begin
      codeReg <= codeNext;
      nrziReg <= nrziNext;
    end
  end

  assign codeGroup = codeReg;
  assign lineBits  = fiberMode ? nrziReg : codeReg;

  // R6
  err_sym_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.selData && txErr) |=> codeGroup == CG_H);

  // R5
  t_sym_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.selT |=> codeGroup == CG_T);

  // R3
  k_sym_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.selK |=> codeGroup == CG_K);

  // R8
  nrzi_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.selJ |=> nrziReg[SYM_W-1] == ($past(nrziReg[0]) ^ 1'b1));

  // R8
  nrzi_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    (codeGroup[0] == 1'b0) |-> nrziReg[0] == nrziReg[1]);

endmodule

// File: rtl/fx_tx_framer.sv
module fx_tx_framer
  import fxTxPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] txData,
  input  logic       txEn,
  input  logic       txErr,
  input  logic       fiberMode,
  output logic [4:0] codeGroup,
  output logic [4:0] lineBits
);

  symStrb_t strb;

  fx_tx_ctrl ctrl_i (
    .clk  (clk),
    .rstN (rstN),
    .txEn (txEn),
    .strb (strb)
  );

  fx_tx_dpath dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .txData    (txData),
    .txErr     (txErr),
    .fiberMode (fiberMode),
    .codeGroup (codeGroup),
    .lineBits  (lineBits)
  );

  // R7
  j_k_ignore_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.selJ || strb.selK) |=> (codeGroup == CG_J || codeGroup == CG_K));

endmodule

// File: tb/fx_tx_framer_tb_top.sv
module fx_tx_framer_tb_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN;
  logic [3:0] txData;
  logic       txEn;
  logic       txErr;
  logic       fiberMode;
  logic [4:0] codeGroup;
  logic [4:0] lineBits;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  // Reference model state: 0 idle, 1 J sent, 2 K sent, 3 data, 4 T sent, 5 R sent
  int         mSt  = 0;
  logic       mLvl = 1'b0;

  localparam logic [4:0] ENC [16] = '{
    5'b11110, 5'b01001, 5'b10100, 5'b10101, 5'b01010, 5'b01011, 5'b01110, 5'b01111,
    5'b10010, 5'b10011, 5'b10110, 5'b10111, 5'b11010, 5'b11011, 5'b11100, 5'b11101};

  always #(CLK_PERIOD/2) clk = ~clk;

  fx_tx_framer dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .txData    (txData),
    .txEn      (txEn),
    .txErr     (txErr),
    .fiberMode (fiberMode),
    .codeGroup (codeGroup),
    .lineBits  (lineBits)
  );

  task automatic check5(input string tag, input string what,
                        input logic [4:0] act, input logic [4:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  // Drive one nibble, let one edge pass, compare against the model.
  task automatic step(input logic en, input logic [3:0] d, input logic er,
                      input string tagOverride);
    logic [4:0] expCg;
    logic [4:0] expLine;
    string      tag;
    txEn = en; txData = d; txErr = er;
    @(posedge clk);
    #2;
    case (mSt)
      0: if (en) begin expCg = 5'b11000; mSt = 1; tag = "R3"; end
         else    begin expCg = 5'b11111;          tag = "R2"; end
      1: begin expCg = 5'b10001; mSt = 2; tag = "R3"; end
      2, 3: if (en) begin
           expCg = er ? 5'b00100 : ENC[d]; mSt = 3; tag = er ? "R6" : "R4";
         end else begin expCg = 5'b01101; mSt = 4; tag = "R5"; end
      4: begin expCg = 5'b00111; mSt = 5; tag = "R5"; end
      default: if (en) begin expCg = 5'b11000; mSt = 1; tag = "R10"; end
               else    begin expCg = 5'b11111; mSt = 0; tag = "R5"; end
    endcase
    for (int b = 4; b >= 0; b--) begin
      mLvl       = mLvl ^ expCg[b];
      expLine[b] = mLvl;
    end
    if (tagOverride != "") tag = tagOverride;
    check5(tag, "codeGroup", codeGroup, expCg);
    if (fiberMode) check5("R8", "lineBits", lineBits, expLine);
    else           check5("R9", "lineBits", lineBits, expCg);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nFails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    rstN = 1'b0; txEn = 1'b0; txData = 4'h0; txErr = 1'b0; fiberMode = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    check5("R1", "codeGroup", codeGroup, 5'b11111);
    check5("R1", "lineBits", lineBits, 5'b00000);
    rstN = 1'b1;

    // R2, R7: idle fill, error ignored while idle
    for (int i = 0; i < 4; i++) step(1'b0, 4'(i), i[0], i[0] ? "R7" : "");
    fiberMode = 1'b0;
    for (int i = 0; i < 3; i++) step(1'b0, 4'hA, 1'b0, "");
    fiberMode = 1'b1;

    // R3, R4, R5: full data sweep, error on J/K edges ignored (R7)
    step(1'b1, 4'h5, 1'b1, "R7");
    step(1'b1, 4'h5, 1'b1, "R7");
    for (int n = 0; n < 16; n++) step(1'b1, 4'(n), 1'b0, "");
    step(1'b0, 4'h0, 1'b1, "R7");
    step(1'b0, 4'h0, 1'b1, "R7");
    step(1'b0, 4'h0, 1'b0, "");

    // Exhaustive sweep: nibble x error x output mode
    for (int fm = 0; fm < 2; fm++) begin
      fiberMode = fm[0];
      step(1'b0, 4'h0, 1'b0, "");
      step(1'b1, 4'h5, 1'b0, "");
      step(1'b1, 4'h5, 1'b0, "");
      for (int er = 0; er < 2; er++)
        for (int n = 0; n < 16; n++) step(1'b1, 4'(n), er[0], "");
      for (int i = 0; i < 3; i++) step(1'b0, 4'h0, 1'b0, "");
    end
    fiberMode = 1'b1;

    // R11: one-cycle and two-cycle enables still give J K T R
    step(1'b1, 4'h5, 1'b0, "R11");
    step(1'b0, 4'h5, 1'b0, "R11");
    step(1'b0, 4'h0, 1'b0, "R11");
    step(1'b0, 4'h0, 1'b0, "R11");
    step(1'b0, 4'h0, 1'b0, "");
    step(1'b1, 4'h5, 1'b0, "R11");
    step(1'b1, 4'h5, 1'b0, "R11");
    step(1'b0, 4'h0, 1'b0, "R11");
    step(1'b0, 4'h0, 1'b0, "R11");
    step(1'b0, 4'h0, 1'b0, "");

    // R10: enable back high while T is pending, then while R is pending
    step(1'b1, 4'h5, 1'b0, "");
    step(1'b1, 4'h5, 1'b0, "");
    step(1'b1, 4'h3, 1'b0, "");
    step(1'b0, 4'h0, 1'b0, "R10");
    step(1'b1, 4'h5, 1'b0, "R10");
    step(1'b1, 4'h5, 1'b0, "R10");
    step(1'b1, 4'h5, 1'b0, "R10");
    step(1'b1, 4'h9, 1'b0, "R10");
    step(1'b0, 4'h0, 1'b0, "");
    step(1'b0, 4'h0, 1'b0, "");
    step(1'b1, 4'h5, 1'b0, "R10");
    step(1'b1, 4'h5, 1'b0, "R10");
    step(1'b1, 4'hC, 1'b0, "");
    step(1'b0, 4'h0, 1'b0, "");
    for (int i = 0; i < 4; i++) step(1'b0, 4'h0, 1'b0, "");

    finishRun();
  end

endmodule